// File: doc/BRIEF.md
# Framed Serial Transmitter with Starvation Halt

This block accepts octets over a byte-wide valid/ready stream, holds them in a three-entry queue, and shifts them out one bit per strobe on a single serial line. Octets go out most significant bit first, in frames of ten octets (80 bits). The `bit_en` strobe paces the line, so the same block can serve any bit rate the surrounding logic derives.

Once a frame has started, every following octet of that frame must already be queued when the line reaches it. If the queue is empty at any octet boundary inside a frame, the block declares an underrun. It ends the frame, drives the line high, sets a sticky status bit and, if the mask allows, pulses an error event. It then waits for a `restart` command, which clears the halt and rewinds the bit and octet counters. Software clears the sticky bit separately with a write-one-to-clear pulse.

Back-pressure on the input stream works as follows. `in_ready` depends only on the queue fill and never on `in_valid`. An octet transfers on a clock edge where both `in_valid` and `in_ready` are high. While `in_ready` is low, the producer keeps `in_data` and `in_valid` held. The queue keeps accepting octets while the transmitter is halted.

Top module: `vframe_tx`

## Requirements
- R1: `in_ready` is high exactly when fewer than 3 octets are queued. An octet is accepted on an edge with `in_valid` and `in_ready` both high. With the line stalled, only three octets are accepted from a producer that keeps `in_valid` high.
- R2: Each octet is sent on `tx_bit` most significant bit first, one bit per clock edge where `bit_en` is high. Octets follow one another with no gap while data is queued. `tx_bit` changes only on edges where `bit_en` is high.
- R3: A frame ends after its 10th octet (80 strobes). If the queue is then empty, the line idles at 1 with no underrun. The next frame starts at the first strobe that finds data queued.
- R4: Out of reset, and at every strobe that finds no frame in progress and an empty queue, `tx_bit` is 1.
- R5: A strobe at the boundary before octets 2 to 10 of a frame that finds the queue empty is an underrun. On that same edge, `tx_bit` goes to 1 and both `halted` and `un_flag` go high.
- R6: On the underrun edge, `tx_err_evt` pulses high for one cycle if `err_mask` is 1. If `err_mask` is 0, `tx_err_evt` stays low. It never pulses at any other time.
- R7: While `halted` is high, strobes send 1 and remove nothing from the queue. The queue keeps accepting octets up to its 3-entry limit.
- R8: A `restart` pulse while halted clears `halted` on that edge and resets the bit and octet counters, so the next queued octet starts a new frame as octet 1. A `restart` pulse while not halted has no effect.
- R9: `un_flag` stays high through `restart`. It clears on the edge where `un_clr` is high.
- R10: After reset, `in_ready` is 1, `tx_bit` is 1, and `halted`, `un_flag` and `tx_err_evt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Octet offered on the input stream |
| in_valid | input | 1 | Input stream valid |
| in_ready | output | 1 | Queue can take an octet |
| bit_en | input | 1 | Bit strobe; one serial bit per high cycle |
| tx_bit | output | 1 | Serial line, MSB first, idles at 1 |
| restart | input | 1 | Restart-transmit command pulse |
| err_mask | input | 1 | Enables the transmit-error event |
| un_clr | input | 1 | Write-one-to-clear for the underrun flag |
| tx_err_evt | output | 1 | One-cycle transmit-error event |
| un_flag | output | 1 | Sticky underrun status |
| halted | output | 1 | Transmitter stopped after an underrun |

## Verification
Every result is registered once after its cause, with no extra pipeline stage. A serial bit appears on the edge of its strobe. The underrun's `halted`, `un_flag` and `tx_err_evt` all appear on the edge of the boundary strobe. `restart` and `un_clr` act on the edge where they are high. `in_ready` changes on the edge after a push or pop. The bench drives each input for one full cycle from a falling edge and samples outputs 1 ns after the next rising edge, so every comparison reads the value due from exactly that edge. Expected serial streams and the underrun position are computed from the octet count of each run: data occupies the first 8N strobes, and strobe 8N is an underrun unless N is a multiple of 10.

// File: rtl/vftx_pkg.sv
package vftx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_RUN  = 2'd1,
    TX_HALT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/vftx_fifo.sv
module vftx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign head  = slots[rd_ptr];
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/vftx_serializer.sv
module vftx_serializer
  import vftx_pkg::*;
#(
  parameter int W            = 8,
  parameter int FRAME_OCTETS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         restart,
  input  logic         q_empty,
  input  logic [W-1:0] q_head,
  output logic         pop,
  output logic         starve,
  output logic         tx_bit,
  output logic         halted
);
  localparam int BIT_W = (W > 1) ? $clog2(W) : 1;
  localparam int OCT_W = (FRAME_OCTETS > 1) ? $clog2(FRAME_OCTETS) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W - 1);
  localparam logic [OCT_W-1:0] LAST_OCT = OCT_W'(FRAME_OCTETS - 1);

  tx_state_e        state;
  logic [W-1:0]     shreg;
  logic [BIT_W-1:0] bit_cnt;
  logic [OCT_W-1:0] oct_cnt;
  logic             at_boundary;

  // bit_cnt counts bits already sent of the current octet; zero means a new octet is due
  assign at_boundary = (bit_cnt == '0);
  assign pop    = bit_en && !q_empty &&
                  ((state == TX_IDLE) || (state == TX_RUN && at_boundary));
  assign starve = bit_en && q_empty && (state == TX_RUN) && at_boundary;
  assign halted = (state == TX_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      shreg   <= '0;
      bit_cnt <= '0;
      oct_cnt <= '0;
      tx_bit  <= 1'b1;
    end else begin
      case (state)
        TX_IDLE: begin
          if (bit_en) begin
            if (!q_empty) begin
              tx_bit  <= q_head[W-1];
              shreg   <= q_head << 1;
              bit_cnt <= BIT_W'(1);
              oct_cnt <= '0;
              state   <= TX_RUN;
            end else begin
              tx_bit <= 1'b1;
            end
          end
        end
        TX_RUN: begin
          if (bit_en) begin
            if (at_boundary) begin
              if (q_empty) begin
                tx_bit <= 1'b1;
                state  <= TX_HALT;
              end else begin
                tx_bit  <= q_head[W-1];
                shreg   <= q_head << 1;
                bit_cnt <= BIT_W'(1);
              end
            end else begin
              tx_bit <= shreg[W-1];
              shreg  <= shreg << 1;
              if (bit_cnt == LAST_BIT) begin
                bit_cnt <= '0;
                if (oct_cnt == LAST_OCT) begin
                  oct_cnt <= '0;
                  state   <= TX_IDLE;
                end else begin
                  oct_cnt <= oct_cnt + OCT_W'(1);
                end
              end else begin
                bit_cnt <= bit_cnt + BIT_W'(1);
              end
            end
          end
        end
        TX_HALT: begin
          tx_bit <= 1'b1;
          if (restart) begin
            bit_cnt <= '0;
            oct_cnt <= '0;
            state   <= TX_IDLE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vftx_status.sv
module vftx_status (
  input  logic clk,
  input  logic rst_n,
  input  logic starve,
  input  logic err_mask,
  input  logic un_clr,
  output logic tx_err_evt,
  output logic un_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_err_evt <= 1'b0;
      un_flag    <= 1'b0;
    end else begin
      tx_err_evt <= starve && err_mask;
      if (starve)      un_flag <= 1'b1;
      else if (un_clr) un_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/vframe_tx.sv
module vframe_tx #(
  parameter int W            = 8,
  parameter int DEPTH        = 3,
  parameter int FRAME_OCTETS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         bit_en,
  output logic         tx_bit,
  input  logic         restart,
  input  logic         err_mask,
  input  logic         un_clr,
  output logic         tx_err_evt,
  output logic         un_flag,
  output logic         halted
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             push, pop, q_empty, q_full, starve;
  logic [W-1:0]     q_head;
  logic [CNT_W-1:0] fifo_cnt;

  assign in_ready = !q_full;
  assign push     = in_valid && in_ready;

  vftx_fifo #(.W(W), .DEPTH(DEPTH)) i_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(in_data), .pop(pop),
    .head(q_head), .empty(q_empty), .full(q_full), .count(fifo_cnt)
  );

  vftx_serializer #(.W(W), .FRAME_OCTETS(FRAME_OCTETS)) i_ser (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .restart(restart),
    .q_empty(q_empty), .q_head(q_head), .pop(pop), .starve(starve),
    .tx_bit(tx_bit), .halted(halted)
  );

  vftx_status i_stat (
    .clk(clk), .rst_n(rst_n), .starve(starve), .err_mask(err_mask),
    .un_clr(un_clr), .tx_err_evt(tx_err_evt), .un_flag(un_flag)
  );
endmodule

// File: rtl/vftx_checker.sv
module vftx_checker #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             bit_en,
  input logic             tx_bit,
  input logic             restart,
  input logic             err_mask,
  input logic             un_clr,
  input logic             tx_err_evt,
  input logic             un_flag,
  input logic             halted,
  input logic             pop,
  input logic [CNT_W-1:0] fifo_cnt
);
  assert_fill_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !pop |=> fifo_cnt == $past(fifo_cnt) + CNT_W'(1));

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  assert_halt_sets_un_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> un_flag);

  assert_evt_follows_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> (tx_err_evt == $past(err_mask)));

  assert_evt_only_on_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err_evt |-> $rose(halted));

  assert_halt_line_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> tx_bit);

  assert_halt_no_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !pop);

  assert_halt_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !restart |=> halted);

  assert_un_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    un_flag && !un_clr |=> un_flag);
endmodule

bind vframe_tx vftx_checker #(.CNT_W(CNT_W)) i_vftx_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .bit_en(bit_en), .tx_bit(tx_bit), .restart(restart), .err_mask(err_mask),
  .un_clr(un_clr), .tx_err_evt(tx_err_evt), .un_flag(un_flag),
  .halted(halted), .pop(pop), .fifo_cnt(fifo_cnt)
);

// File: tb/test_vframe_tx.sv
`timescale 1ns/1ps
module test_vframe_tx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] in_data;
  logic       in_valid, in_ready, bit_en, tx_bit, restart, err_mask, un_clr;
  logic       tx_err_evt, un_flag, halted;

  int checks = 0;
  int fails  = 0;
  int nbytes = 0;
  int ptr    = 0;
  int evt_cnt = 0;
  logic [7:0] mem [16];

  always #2.5 clk = ~clk;

  vframe_tx i_vframe_tx (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .bit_en(bit_en), .tx_bit(tx_bit), .restart(restart),
    .err_mask(err_mask), .un_clr(un_clr), .tx_err_evt(tx_err_evt),
    .un_flag(un_flag), .halted(halted)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at the falling edge, sample 1 ns after the rising edge
  task automatic step(input logic strobe, input logic rcmd, input logic ccmd);
    logic acc;
    in_valid = (ptr < nbytes);
    in_data  = (ptr < 16) ? mem[ptr] : 8'h00;
    bit_en   = strobe;
    restart  = rcmd;
    un_clr   = ccmd;
    #1 acc = in_valid && in_ready;
    @(posedge clk);
    #1;
    if (acc) ptr++;
    if (tx_err_evt) evt_cnt++;
    @(negedge clk);
    in_valid = 1'b0; bit_en = 1'b0; restart = 1'b0; un_clr = 1'b0;
  endtask

  // strobe through n queued/queueable octets plus 4 strobes past the end
  task automatic stream(input int n, input int gap);
    int sidx = 0;
    int cyc  = 0;
    while (sidx < 8*n + 4) begin
      logic st;
      st = (cyc % gap) == 0;
      step(st, 1'b0, 1'b0);
      cyc++;
      if (st) begin
        int expb;
        if (sidx < 8*n) begin
          expb = int'(mem[sidx/8][7 - (sidx%8)]);
          check(tx_bit == expb[0], "R2 serial bit", int'(tx_bit), expb);
        end else if (n % 10 != 0) begin
          check(tx_bit == 1'b1, "R5 line after underrun", int'(tx_bit), 1);
        end else begin
          check(tx_bit == 1'b1, "R3 idle after full frame", int'(tx_bit), 1);
        end
        sidx++;
      end else if (sidx > 0 && sidx <= 8*n) begin
        int expb;
        expb = int'(mem[(sidx-1)/8][7 - ((sidx-1)%8)]);
        check(tx_bit == expb[0], "R2 hold between strobes", int'(tx_bit), expb);
      end
    end
  endtask

  task automatic close_run(input bit exp_un, input logic mask);
    check(halted == exp_un, "R5 halted", int'(halted), int'(exp_un));
    check(un_flag == exp_un, "R5 un_flag", int'(un_flag), int'(exp_un));
    check(evt_cnt == int'(exp_un && mask), "R6 event count", evt_cnt, int'(exp_un && mask));
    step(1'b0, 1'b1, 1'b0);
    check(halted == 1'b0, "R8 restart clears or is ignored", int'(halted), 0);
    check(un_flag == exp_un, "R9 flag survives restart", int'(un_flag), int'(exp_un));
    step(1'b0, 1'b0, 1'b1);
    check(un_flag == 1'b0, "R9 write-one-to-clear", int'(un_flag), 0);
  endtask

  task automatic run(input int n, input logic mask, input int gap);
    int pre;
    nbytes = n; ptr = 0; evt_cnt = 0; err_mask = mask;
    for (int i = 0; i < 16; i++) mem[i] = 8'((i * 37 + n * 11 + 5) ^ (i << 5));
    for (int c = 0; c < 4; c++) step(1'b0, 1'b0, 1'b0);
    pre = (n < 3) ? n : 3;
    check(ptr == pre, "R1 accepted while stalled", ptr, pre);
    check(in_ready == (n < 3), "R1 ready vs fill", int'(in_ready), int'(n < 3));
    stream(n, gap);
    close_run(n % 10 != 0, mask);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; bit_en = 1'b0;
    restart = 1'b0; err_mask = 1'b0; un_clr = 1'b0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(in_ready == 1'b1, "R10 ready", int'(in_ready), 1);
    check(tx_bit == 1'b1, "R10 line", int'(tx_bit), 1);
    check(halted == 1'b0, "R10 halted", int'(halted), 0);
    check(un_flag == 1'b0, "R10 flag", int'(un_flag), 0);
    check(tx_err_evt == 1'b0, "R10 event", int'(tx_err_evt), 0);

    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, 1'b0);
      check(tx_bit == 1'b1, "R4 idle strobe", int'(tx_bit), 1);
    end

    for (int n = 1; n <= 12; n++) run(n, logic'(n % 2), 1 + (n % 3));

    // halted transmitter keeps the line high and the queue intact (R7)
    nbytes = 2; ptr = 0; evt_cnt = 0; err_mask = 1'b1;
    for (int i = 0; i < 16; i++) mem[i] = 8'(8'hA5 ^ (i * 29));
    for (int c = 0; c < 4; c++) step(1'b0, 1'b0, 1'b0);
    stream(2, 1);
    check(halted == 1'b1, "R5 halted before refill", int'(halted), 1);
    for (int i = 0; i < 16; i++) mem[i] = 8'(8'h3C + i * 71);
    nbytes = 3; ptr = 0;
    for (int k = 0; k < 16; k++) begin
      step(1'b1, 1'b0, 1'b0);
      check(tx_bit == 1'b1, "R7 halted line", int'(tx_bit), 1);
    end
    check(ptr == 3, "R7 refill accepted", ptr, 3);
    check(in_ready == 1'b0, "R7 queue not drained", int'(in_ready), 0);
    step(1'b0, 1'b1, 1'b0);
    check(halted == 1'b0, "R8 restart", int'(halted), 0);
    evt_cnt = 0;
    stream(3, 2);
    close_run(1'b1, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule